// File: doc/BRIEF.md
# Parameter Block Fetch Sequencer

This block fills a set of configuration registers from a parameter block held in system memory. The host first writes the block's byte address as two 16-bit halves, then writes a start command. The sequencer then issues one 32-bit read per memory word on a simple request/acknowledge bus, unpacks each returned word into the ring configuration fields, and sets a done flag when the last field is in place. An interrupt output follows the done flag when the host has enabled it.

A layout bit picks how the block is organised. In the compact layout every entry is 16 bits, so one bus word carries two entries. In the wide layout every entry is 32 bits, and one word carries one entry. The bus width is the same in both layouts. The fetch state machine takes a step only on alternate clock cycles. The bus response capture and the host register port work on every cycle.

Top module: `ibf_seq`

## Requirements
- R1: After reset, init_done, irq and rd_req are 0, all five configuration outputs are 0, and the control word read back at host offset 0 is 0.
- R2: The host register map is: offset 0 is control, offset 1 is the base address bits 15:0, and offset 2 is the base address bits 31:16. Writing offset 0 with bit 0 = 1 while idle starts a fetch. The first rd_addr is {offset 2, offset 1}.
- R3: Every access is one 32-bit word read, and rd_addr grows by 4 on each access. A fetch makes exactly 4 accesses in compact layout (control bit 3 = 0) and 5 in wide layout (bit 3 = 1). rd_req stays high with rd_addr stable until rd_ack.
- R4: Compact layout, word w read at base+4w, entries taken low half first. w0[15:0] goes to cfg_mode and w0[31:16] to rx_ring_base[15:0]. w1[15:0] goes to rx_ring_base[31:16] and w1[31:16] to rx_ring_len. w2 goes to tx_ring_base. w3[15:0] goes to tx_ring_len.
- R5: Wide layout. w0[15:0] goes to cfg_mode, w1 to rx_ring_base, w2[15:0] to rx_ring_len, w3 to tx_ring_base, and w4[15:0] to tx_ring_len.
- R6: init_done rises on the same edge that loads the last field, and the busy flag (control read bit 0) reads 0 from then on.
- R7: irq equals init_done AND the interrupt enable (control bit 1).
- R8: init_done (control bit 2) is cleared by writing 1 to bit 2, and writing 0 there leaves it set. When completion and a clearing write fall on the same edge, init_done ends up set.
- R9: The sequencer runs at half rate. rd_addr and init_done change only on even-numbered clock edges counted from reset release.
- R10: A start command written while a fetch is busy is ignored. No extra accesses follow, and the fields keep the values loaded from the first base address.
- R11: Offsets 1 and 2 read back the last value written. The control read returns busy in bit 0, enable in bit 1, done in bit 2 and layout in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read response valid, one cycle |
| rd_data | input | 32 | Read response word |
| init_done | output | 1 | Block fully loaded |
| irq | output | 1 | Interrupt |
| cfg_mode | output | 16 | Loaded mode entry |
| rx_ring_base | output | 32 | Receive ring base address |
| rx_ring_len | output | 16 | Receive ring length entry |
| tx_ring_base | output | 32 | Transmit ring base address |
| tx_ring_len | output | 16 | Transmit ring length entry |

## Verification
The setting of the done flag at completion and a host write that clears the flag can land on the same clock edge. The bench first measures, with a fixed base, layout and response delay, how many edges lie between the sampled start command and the rise of init_done. It then repeats that same fetch and places a clearing write on each edge from two before to two after the measured completion edge. It expects init_done and irq to stay set when the clear lands no later than completion, and to be clear when it lands after.

// File: rtl/ibf_pkg.sv
package ibf_pkg;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 3;
    localparam int BYTE_SH = 2;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_BLO  = 2'd1;
    localparam logic [1:0] OFS_BHI  = 2'd2;

    localparam int CB_GO   = 0;
    localparam int CB_IE   = 1;
    localparam int CB_DONE = 2;
    localparam int CB_WIDE = 3;

    localparam logic [IDX_W-1:0] LAST_COMPACT = 3'd3;
    localparam logic [IDX_W-1:0] LAST_WIDE    = 3'd4;

    typedef enum logic {ST_IDLE, ST_FETCH} fetch_st_e;

    typedef struct packed {
        logic [HALF_W-1:0] mode;
        logic [WORD_W-1:0] rx_base;
        logic [HALF_W-1:0] rx_len;
        logic [WORD_W-1:0] tx_base;
        logic [HALF_W-1:0] tx_len;
    } ring_cfg_t;

    typedef struct packed {
        logic              ld;
        logic              wide;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } word_ev_t;

    function automatic logic [IDX_W-1:0] last_index(input logic wide);
        return wide ? LAST_WIDE : LAST_COMPACT;
    endfunction
endpackage

// File: rtl/ibf_tick.sv
module ibf_tick (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic phase;
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end
    assign tick = phase;
endmodule

// File: rtl/ibf_regs.sv
module ibf_regs
    import ibf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              load_done,
    output logic              go,
    output logic              wide,
    output logic [WORD_W-1:0] base,
    output logic              done,
    output logic              irq
);
    logic [HALF_W-1:0] blo_q, bhi_q;
    logic              ie_q, wide_q, done_q;
    logic              wr_ctrl, clr_done;

    assign wr_ctrl  = host_we && (host_addr == OFS_CTRL);
    assign clr_done = wr_ctrl && host_wdata[CB_DONE];
    assign go       = wr_ctrl && host_wdata[CB_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            blo_q  <= '0;
            bhi_q  <= '0;
            ie_q   <= 1'b0;
            wide_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (host_we && host_addr == OFS_BLO) blo_q <= host_wdata;
            if (host_we && host_addr == OFS_BHI) bhi_q <= host_wdata;
            if (wr_ctrl) begin
                ie_q   <= host_wdata[CB_IE];
                wide_q <= host_wdata[CB_WIDE];
            end
            if (load_done)     done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_CTRL: begin
                host_rdata[CB_GO]   = busy;
                host_rdata[CB_IE]   = ie_q;
                host_rdata[CB_DONE] = done_q;
                host_rdata[CB_WIDE] = wide_q;
            end
            OFS_BLO: host_rdata = blo_q;
            OFS_BHI: host_rdata = bhi_q;
            default: host_rdata = '0;
        endcase
    end

    assign wide = wide_q;
    assign base = {bhi_q, blo_q};
    assign done = done_q;
    assign irq  = done_q && ie_q;
endmodule

// File: rtl/ibf_fetch.sv
module ibf_fetch
    import ibf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  logic              wide,
    input  logic [WORD_W-1:0] base,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output word_ev_t          ev,
    output logic              load_done
);
    fetch_st_e         state;
    logic              pend;
    logic              wide_q;
    logic [WORD_W-1:0] base_q;
    logic [IDX_W-1:0]  idx;
    logic              resp_vld;
    logic [WORD_W-1:0] resp_data;
    logic              last;

    assign busy    = pend || (state == ST_FETCH);
    assign rd_req  = (state == ST_FETCH) && !resp_vld;
    assign rd_addr = base_q + (WORD_W'(idx) << BYTE_SH);
    assign last    = (idx == last_index(wide_q));

    always_comb begin
        ev.ld   = tick && (state == ST_FETCH) && resp_vld;
        ev.wide = wide_q;
        ev.idx  = idx;
        ev.data = resp_data;
    end
    assign load_done = ev.ld && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend      <= 1'b0;
            wide_q    <= 1'b0;
            base_q    <= '0;
            idx       <= '0;
            resp_vld  <= 1'b0;
            resp_data <= '0;
        end else begin
            if (go && !busy) pend <= 1'b1;
            if (rd_req && rd_ack) begin
                resp_vld  <= 1'b1;
                resp_data <= rd_data;
            end
            if (tick) begin
                case (state)
                    ST_IDLE: if (pend) begin
                        state  <= ST_FETCH;
                        pend   <= 1'b0;
                        base_q <= base;
                        wide_q <= wide;
                        idx    <= '0;
                    end
                    ST_FETCH: if (resp_vld) begin
                        resp_vld <= 1'b0;
                        idx      <= idx + 1'b1;
                        if (last) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ibf_unpack.sv
module ibf_unpack
    import ibf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_ev_t  ev,
    output ring_cfg_t cfg
);
    logic [HALF_W-1:0] lo, hi;
    assign lo = ev.data[HALF_W-1:0];
    assign hi = ev.data[WORD_W-1:HALF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (ev.ld) begin
            if (ev.wide) begin
                case (ev.idx)
                    3'd0: cfg.mode    <= lo;
                    3'd1: cfg.rx_base <= ev.data;
                    3'd2: cfg.rx_len  <= lo;
                    3'd3: cfg.tx_base <= ev.data;
                    3'd4: cfg.tx_len  <= lo;
                    default: ;
                endcase
            end else begin
                case (ev.idx)
                    3'd0: begin
                        cfg.mode                 <= lo;
                        cfg.rx_base[HALF_W-1:0]  <= hi;
                    end
                    3'd1: begin
                        cfg.rx_base[WORD_W-1:HALF_W] <= lo;
                        cfg.rx_len                   <= hi;
                    end
                    3'd2: cfg.tx_base <= ev.data;
                    3'd3: cfg.tx_len  <= lo;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ibf_seq.sv
module ibf_seq
    import ibf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              init_done,
    output logic              irq,
    output logic [HALF_W-1:0] cfg_mode,
    output logic [WORD_W-1:0] rx_ring_base,
    output logic [HALF_W-1:0] rx_ring_len,
    output logic [WORD_W-1:0] tx_ring_base,
    output logic [HALF_W-1:0] tx_ring_len
);
    logic              tick, busy, load_done, go, wide;
    logic [WORD_W-1:0] base;
    word_ev_t          ev;
    ring_cfg_t         cfg;

    ibf_tick u_tick (.clk(clk), .rst(rst), .tick(tick));

    ibf_regs u_regs (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .load_done(load_done), .go(go), .wide(wide), .base(base),
        .done(init_done), .irq(irq)
    );

    ibf_fetch u_fetch (
        .clk(clk), .rst(rst), .tick(tick), .go(go), .wide(wide), .base(base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .ev(ev), .load_done(load_done)
    );

    ibf_unpack u_unpack (.clk(clk), .rst(rst), .ev(ev), .cfg(cfg));

    assign cfg_mode     = cfg.mode;
    assign rx_ring_base = cfg.rx_base;
    assign rx_ring_len  = cfg.rx_len;
    assign tx_ring_base = cfg.tx_base;
    assign tx_ring_len  = cfg.tx_len;
endmodule

// File: rtl/ibf_seq_chk.sv
module ibf_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_we,
    input logic [1:0]  host_addr,
    input logic        clr_bit,
    input logic        rd_req,
    input logic        rd_ack,
    input logic [31:0] rd_addr,
    input logic        init_done,
    input logic        irq,
    input logic        busy,
    input logic        tick
);
    // R3: request held with a stable address until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    // R8: done stays set unless the host writes 1 to its bit
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        init_done && !(host_we && host_addr == 2'd0 && clr_bit) |=> init_done);

    // R6: completion leaves the sequencer idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> !busy);

    // R9: address moves only on an edge where the half-rate enable was high
    p_half_rate_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_addr) |-> $past(tick));

    // R7: interrupt never without done
    p_irq_done_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> init_done);
endmodule

bind ibf_seq ibf_seq_chk u_chk (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .clr_bit(host_wdata[2]), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_addr(rd_addr), .init_done(init_done), .irq(irq), .busy(busy),
    .tick(tick)
);

// File: tb/tb_ibf_seq.sv
module tb_ibf_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        init_done, irq;
    logic [15:0] cfg_mode, rx_ring_len, tx_ring_len;
    logic [31:0] rx_ring_base, tx_ring_base;

    ibf_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0;
    int acc_cnt = 0, addr_err = 0, par_err = 0;
    int delay = 0, wcnt = 0;
    int done_edge = 0, go_edge = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] prev_addr = '0;
    logic        prev_done = 1'b0;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and monitors, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            if (!rst) begin
                if (rd_addr !== prev_addr && (cyc % 2) != 0) par_err++;
                if (init_done && !prev_done) begin
                    done_edge = cyc;
                    if ((cyc % 2) != 0) par_err++;
                end
                prev_addr = rd_addr;
                prev_done = init_done;
                if (rd_req) begin
                    if (wcnt >= delay) begin
                        if (rd_addr !== cur_base + 32'(acc_cnt) * 4) addr_err++;
                        rd_ack  = 1'b1;
                        rd_data = memf(rd_addr);
                        acc_cnt++;
                        wcnt = 0;
                    end else wcnt++;
                end else wcnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = 2'd0; host_wdata = '0;
    endtask

    function automatic logic [15:0] ctrlw(input bit go, input bit ie, input bit clr, input bit wide);
        return {12'd0, wide, clr, ie, go};
    endfunction

    task automatic start_aligned(input bit ie, input bit wide);
        @(negedge clk);
        while ((cyc % 2) != 0) @(negedge clk);
        host_we = 1'b1; host_addr = 2'd0; host_wdata = ctrlw(1, ie, 0, wide);
        go_edge = cyc + 1;
        @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic setup(input logic [31:0] b, input bit ie, input bit wide, input int d);
        hwrite(2'd1, b[15:0]);
        hwrite(2'd2, b[31:16]);
        hwrite(2'd0, ctrlw(0, ie, 1, wide));
        cur_base = b; delay = d; acc_cnt = 0; addr_err = 0; par_err = 0;
    endtask

    task automatic wait_done();
        while (init_done !== 1'b1) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_cfg(input logic [31:0] b, input bit wide, input string tag);
        logic [31:0] w0, w1, w2, w3, w4;
        w0 = memf(b); w1 = memf(b + 4); w2 = memf(b + 8); w3 = memf(b + 12); w4 = memf(b + 16);
        if (wide) begin
            ck(cfg_mode == w0[15:0], {tag, " R5 mode"}, cfg_mode, w0[15:0]);
            ck(rx_ring_base == w1, {tag, " R5 rxb"}, rx_ring_base, w1);
            ck(rx_ring_len == w2[15:0], {tag, " R5 rxl"}, rx_ring_len, w2[15:0]);
            ck(tx_ring_base == w3, {tag, " R5 txb"}, tx_ring_base, w3);
            ck(tx_ring_len == w4[15:0], {tag, " R5 txl"}, tx_ring_len, w4[15:0]);
        end else begin
            ck(cfg_mode == w0[15:0], {tag, " R4 mode"}, cfg_mode, w0[15:0]);
            ck(rx_ring_base == {w1[15:0], w0[31:16]}, {tag, " R4 rxb"}, rx_ring_base, {w1[15:0], w0[31:16]});
            ck(rx_ring_len == w1[31:16], {tag, " R4 rxl"}, rx_ring_len, w1[31:16]);
            ck(tx_ring_base == w2, {tag, " R4 txb"}, tx_ring_base, w2);
            ck(tx_ring_len == w3[15:0], {tag, " R4 txl"}, tx_ring_len, w3[15:0]);
        end
    endtask

    logic [31:0] bases [4] = '{32'h0000_0100, 32'h1234_5670, 32'h8000_FFF8, 32'hFFFF_FFF0};
    int lat;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        ck(init_done == 0 && irq == 0, "R1 done/irq", {init_done, irq}, 0);
        ck(rd_req == 0, "R1 rd_req", rd_req, 0);
        ck(cfg_mode == 0 && rx_ring_base == 0 && rx_ring_len == 0 && tx_ring_base == 0 && tx_ring_len == 0,
           "R1 cfg", rx_ring_base, 0);
        ck(host_rdata == 0, "R1 ctrl read", host_rdata, 0);

        // R11 base readback
        hwrite(2'd1, 16'hBEEC);
        hwrite(2'd2, 16'h0F0E);
        host_addr = 2'd1; #1;
        ck(host_rdata == 16'hBEEC, "R11 lo readback", host_rdata, 16'hBEEC);
        host_addr = 2'd2; #1;
        ck(host_rdata == 16'h0F0E, "R11 hi readback", host_rdata, 16'h0F0E);
        host_addr = 2'd0;

        // sweep: bases x layouts x response delays
        for (int bi = 0; bi < 4; bi++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int d = 0; d < 4; d++) begin
                    bit ie;
                    ie = ((bi + d) % 2) == 1;
                    setup(bases[bi], ie, wd[0], d);
                    start_aligned(ie, wd[0]);
                    wait_done();
                    ck(acc_cnt == (wd ? 5 : 4), "R3 access count", acc_cnt, wd ? 5 : 4);
                    ck(addr_err == 0, "R2 R3 address sequence", addr_err, 0);
                    check_cfg(bases[bi], wd[0], "sweep");
                    ck(init_done == 1, "R6 done set", init_done, 1);
                    ck(host_rdata[0] == 0, "R6 busy clear", host_rdata[0], 0);
                    ck(irq == ie, "R7 irq", irq, ie);
                    ck(host_rdata[3:1] == {wd[0], 1'b1, ie}, "R11 ctrl read", host_rdata[3:1], {wd[0], 1'b1, ie});
                    ck(par_err == 0, "R9 half rate", par_err, 0);
                end
            end
        end

        // R8 write 0 leaves done, write 1 clears
        hwrite(2'd0, ctrlw(0, 1, 0, 0));
        @(negedge clk);
        ck(init_done == 1 && irq == 1, "R8 zero keeps done", {init_done, irq}, 2'b11);
        hwrite(2'd0, ctrlw(0, 1, 1, 0));
        ck(init_done == 0 && irq == 0, "R8 one clears done", {init_done, irq}, 0);

        // R10 start while busy ignored
        setup(32'h0000_4000, 1, 0, 3);
        start_aligned(1, 0);
        hwrite(2'd1, 16'h7000);
        hwrite(2'd0, ctrlw(1, 1, 0, 0));
        wait_done();
        repeat (20) @(negedge clk);
        ck(acc_cnt == 4, "R10 no extra accesses", acc_cnt, 4);
        check_cfg(32'h0000_4000, 0, "R10");
        host_addr = 2'd1; #1;
        ck(host_rdata == 16'h7000, "R11 lo written while busy", host_rdata, 16'h7000);
        host_addr = 2'd0;

        // R8 collision: calibrate latency then sweep clear timing
        setup(32'h0000_2000, 1, 0, 1);
        start_aligned(1, 0);
        wait_done();
        lat = done_edge - go_edge;
        for (int k = -2; k <= 2; k++) begin
            setup(32'h0000_2000, 1, 0, 1);
            start_aligned(1, 0);
            while (cyc != go_edge + lat + k - 1) @(negedge clk);
            host_we = 1'b1; host_addr = 2'd0; host_wdata = ctrlw(0, 1, 1, 0);
            @(negedge clk);
            host_we = 1'b0; host_wdata = '0;
            repeat (12) @(negedge clk);
            ck(init_done == (k <= 0), $sformatf("R8 set vs clear offset %0d", k), init_done, (k <= 0));
            ck(irq == (k <= 0), $sformatf("R7 irq at offset %0d", k), irq, (k <= 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule